// File: doc/BRIEF.md
# USB Full-Speed Transceiver Mode Interface

This block is the digital glue between a USB link controller and an analog full-speed line driver with its receivers. On the transmit side it turns the controller's two shared pins into drive values and an output enable for the D+ and D- lines. Two encodings are supported. In data/single-ended-zero encoding, one pin carries the data and the other forces a single-ended zero. In line-state encoding, the two pins drive D+ and D- directly.

On the receive side, the block takes the single-ended D+ and D- comparator levels and the differential receiver bit. From these it produces a receive-data output that holds its value through single-ended line states. When the shared pins are configured as bidirectional and the controller is not transmitting, the block also drives the shared pins back toward the controller. Every output is registered, so each output reflects the inputs of the previous clock cycle.

Top module: `usb_fs_xcvr_if`

## Requirements
- R1: With encoding select `enc_dat_se0_i`=1 and the line drivers enabled, while `se0_vm_i`=0, `dp_drv_o` equals `dat_vp_i` and `dm_drv_o` equals its inverse.
- R2: With `enc_dat_se0_i`=1 and the line drivers enabled, while `se0_vm_i`=1, both `dp_drv_o` and `dm_drv_o` are 0.
- R3: With `enc_dat_se0_i`=0 (line-state encoding) and the line drivers enabled, `dp_drv_o` equals `dat_vp_i` and `dm_drv_o` equals `se0_vm_i`.
- R4: `line_oe_o` is 1 only when `oe_ni`=0, `line_rst_ni`=1 and `por_i`=0. Whenever `line_oe_o` is 0, both drive values are 0.
- R5: With `bidir_i`=0, `pin_oe_o`, `dat_vp_o` and `se0_vm_o` are all 0.
- R6: With `bidir_i`=1, `pin_oe_o` equals `oe_ni`. While `pin_oe_o` is 0, `dat_vp_o` and `se0_vm_o` are 0.
- R7: In bidirectional line-state receive (`bidir_i`=1, `oe_ni`=1, `enc_dat_se0_i`=0), `dat_vp_o` equals `dp_rx_i` and `se0_vm_o` equals `dm_rx_i`.
- R8: In bidirectional data/SE0 receive, `se0_vm_o` is 1 exactly when `dp_rx_i` and `dm_rx_i` are both 0. `dat_vp_o` carries the receive value of R9/R10, or `dp_rx_i` while `suspend_i`=1.
- R9: While receiving (`oe_ni`=1, `suspend_i`=0) with `dp_rx_i`≠`dm_rx_i`, `rcv_o` equals `rcv_diff_i`, and that value is stored as the held value.
- R10: While receiving with `dp_rx_i`=`dm_rx_i`, `rcv_o` equals the stored held value. The held value is 0 after reset.
- R11: While `oe_ni`=0 or `suspend_i`=1, `rcv_o` is 0 and the held value is left unchanged.
- R12: Every output changes exactly one clock after its inputs, and all outputs are 0 while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset of the output registers |
| enc_dat_se0_i | input | 1 | 1 = data/SE0 encoding, 0 = line-state encoding |
| bidir_i | input | 1 | 1 = shared pins bidirectional |
| oe_ni | input | 1 | Active-low transmit enable from the controller |
| suspend_i | input | 1 | Differential receiver powered down |
| line_rst_ni | input | 1 | Active-low reset pin, forces drivers off |
| por_i | input | 1 | Internal power-on reset, active high |
| dat_vp_i | input | 1 | Shared data / D+ pin, input level |
| se0_vm_i | input | 1 | Shared SE0 / D- pin, input level |
| dp_rx_i | input | 1 | D+ single-ended receiver level |
| dm_rx_i | input | 1 | D- single-ended receiver level |
| rcv_diff_i | input | 1 | Differential receiver output |
| dp_drv_o | output | 1 | D+ drive value |
| dm_drv_o | output | 1 | D- drive value |
| line_oe_o | output | 1 | D+/D- driver enable |
| rcv_o | output | 1 | Receive data to the controller |
| dat_vp_o | output | 1 | Shared data / D+ pin, output value |
| se0_vm_o | output | 1 | Shared SE0 / D- pin, output value |
| pin_oe_o | output | 1 | Enable for the shared pin outputs |

## Verification
Each assertion compares an output with inputs sampled on the previous clock. The assertions therefore assume that every input stays stable across each rising edge and is a defined 0 or 1. None of them assumes any relation between the inputs: single-ended zero, single-ended one, suspend combined with transmit, and reset combined with transmit are all legal. The stimulus changes inputs only on falling edges. It walks every combination of the eleven control and line inputs in counting order. Because the line levels change fastest, both the hold path and the update path of the receive register are reached from both stored values.

// File: rtl/usb_fs_xcvr_pkg.sv
package usb_fs_xcvr_pkg;

    typedef struct packed {
        logic dp_drv;
        logic dm_drv;
        logic line_oe;
        logic rcv;
        logic dat_vp;
        logic se0_vm;
        logic pin_oe;
        logic rcv_hold;
    } xcvr_state_t;

    localparam xcvr_state_t XCVR_RESET = '{default: 1'b0};

endpackage

// File: rtl/usb_fs_tx_enc.sv
module usb_fs_tx_enc (
    input  logic enc_dat_se0_i,
    input  logic oe_ni,
    input  logic line_rst_ni,
    input  logic por_i,
    input  logic dat_vp_i,
    input  logic se0_vm_i,
    output logic dp_o,
    output logic dm_o,
    output logic oe_o
);
    logic drive_en;
    logic dp_raw;
    logic dm_raw;

    always_comb begin
        drive_en = !oe_ni && line_rst_ni && !por_i;
        if (enc_dat_se0_i) begin
            // Forced single-ended zero overrides the data bit
            dp_raw = se0_vm_i ? 1'b0 : dat_vp_i;
            dm_raw = se0_vm_i ? 1'b0 : !dat_vp_i;
        end else begin
            dp_raw = dat_vp_i;
            dm_raw = se0_vm_i;
        end
        oe_o = drive_en;
        dp_o = drive_en && dp_raw;
        dm_o = drive_en && dm_raw;
    end
endmodule

// File: rtl/usb_fs_rx_dec.sv
module usb_fs_rx_dec (
    input  logic enc_dat_se0_i,
    input  logic bidir_i,
    input  logic oe_ni,
    input  logic suspend_i,
    input  logic dp_rx_i,
    input  logic dm_rx_i,
    input  logic rcv_diff_i,
    input  logic hold_q_i,
    output logic rcv_o,
    output logic hold_d_o,
    output logic dat_vp_o,
    output logic se0_vm_o,
    output logic pin_oe_o
);
    logic rx_active;
    logic line_diff;
    logic rcv_val;

    always_comb begin
        rx_active = oe_ni && !suspend_i;
        line_diff = dp_rx_i ^ dm_rx_i;
        rcv_val   = line_diff ? rcv_diff_i : hold_q_i;

        rcv_o    = rx_active && rcv_val;
        hold_d_o = (rx_active && line_diff) ? rcv_diff_i : hold_q_i;

        pin_oe_o = bidir_i && oe_ni;
        dat_vp_o = 1'b0;
        se0_vm_o = 1'b0;
        if (pin_oe_o) begin
            if (enc_dat_se0_i) begin
                dat_vp_o = suspend_i ? dp_rx_i : rcv_val;
                se0_vm_o = !dp_rx_i && !dm_rx_i;
            end else begin
                dat_vp_o = dp_rx_i;
                se0_vm_o = dm_rx_i;
            end
        end
    end
endmodule

// File: rtl/usb_fs_xcvr_if.sv
module usb_fs_xcvr_if
    import usb_fs_xcvr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enc_dat_se0_i,
    input  logic bidir_i,
    input  logic oe_ni,
    input  logic suspend_i,
    input  logic line_rst_ni,
    input  logic por_i,
    input  logic dat_vp_i,
    input  logic se0_vm_i,
    input  logic dp_rx_i,
    input  logic dm_rx_i,
    input  logic rcv_diff_i,
    output logic dp_drv_o,
    output logic dm_drv_o,
    output logic line_oe_o,
    output logic rcv_o,
    output logic dat_vp_o,
    output logic se0_vm_o,
    output logic pin_oe_o
);
    xcvr_state_t state_d;
    xcvr_state_t state_q;

    logic tx_dp, tx_dm, tx_oe;
    logic rx_rcv, rx_hold, rx_dat, rx_se0, rx_pin_oe;

    usb_fs_tx_enc u_tx (
        .enc_dat_se0_i (enc_dat_se0_i),
        .oe_ni         (oe_ni),
        .line_rst_ni   (line_rst_ni),
        .por_i         (por_i),
        .dat_vp_i      (dat_vp_i),
        .se0_vm_i      (se0_vm_i),
        .dp_o          (tx_dp),
        .dm_o          (tx_dm),
        .oe_o          (tx_oe)
    );

    usb_fs_rx_dec u_rx (
        .enc_dat_se0_i (enc_dat_se0_i),
        .bidir_i       (bidir_i),
        .oe_ni         (oe_ni),
        .suspend_i     (suspend_i),
        .dp_rx_i       (dp_rx_i),
        .dm_rx_i       (dm_rx_i),
        .rcv_diff_i    (rcv_diff_i),
        .hold_q_i      (state_q.rcv_hold),
        .rcv_o         (rx_rcv),
        .hold_d_o      (rx_hold),
        .dat_vp_o      (rx_dat),
        .se0_vm_o      (rx_se0),
        .pin_oe_o      (rx_pin_oe)
    );

    always_comb begin
        state_d          = state_q;
        state_d.dp_drv   = tx_dp;
        state_d.dm_drv   = tx_dm;
        state_d.line_oe  = tx_oe;
        state_d.rcv      = rx_rcv;
        state_d.rcv_hold = rx_hold;
        state_d.dat_vp   = rx_dat;
        state_d.se0_vm   = rx_se0;
        state_d.pin_oe   = rx_pin_oe;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= XCVR_RESET;
        else         state_q <= state_d;
    end

    assign dp_drv_o  = state_q.dp_drv;
    assign dm_drv_o  = state_q.dm_drv;
    assign line_oe_o = state_q.line_oe;
    assign rcv_o     = state_q.rcv;
    assign dat_vp_o  = state_q.dat_vp;
    assign se0_vm_o  = state_q.se0_vm;
    assign pin_oe_o  = state_q.pin_oe;
endmodule

// File: rtl/usb_fs_xcvr_if_chk.sv
module usb_fs_xcvr_if_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic enc_dat_se0_i,
    input logic bidir_i,
    input logic oe_ni,
    input logic suspend_i,
    input logic line_rst_ni,
    input logic por_i,
    input logic dat_vp_i,
    input logic se0_vm_i,
    input logic dp_rx_i,
    input logic dm_rx_i,
    input logic rcv_diff_i,
    input logic dp_drv_o,
    input logic dm_drv_o,
    input logic line_oe_o,
    input logic rcv_o,
    input logic dat_vp_o,
    input logic se0_vm_o,
    input logic pin_oe_o
);
    logic tx_on;
    assign tx_on = !oe_ni && line_rst_ni && !por_i;

    assert_datse0_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_on && enc_dat_se0_i && !se0_vm_i) |=>
            (line_oe_o && dp_drv_o == $past(dat_vp_i) && dm_drv_o == !$past(dat_vp_i)));

    assert_datse0_force_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_on && enc_dat_se0_i && se0_vm_i) |=> (line_oe_o && !dp_drv_o && !dm_drv_o));

    assert_vpvm_direct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_on && !enc_dat_se0_i) |=>
            (line_oe_o && dp_drv_o == $past(dat_vp_i) && dm_drv_o == $past(se0_vm_i)));

    assert_line_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_ni || !line_rst_ni || por_i) |=> (!line_oe_o && !dp_drv_o && !dm_drv_o));

    assert_unidir_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bidir_i |=> (!pin_oe_o && !dat_vp_o && !se0_vm_o));

    assert_bidir_dir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bidir_i |=> (pin_oe_o == $past(oe_ni)));

    assert_vpvm_rx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bidir_i && oe_ni && !enc_dat_se0_i) |=>
            (dat_vp_o == $past(dp_rx_i) && se0_vm_o == $past(dm_rx_i)));

    assert_se0_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bidir_i && oe_ni && enc_dat_se0_i) |=>
            (se0_vm_o == ($past(dp_rx_i) == 1'b0 && $past(dm_rx_i) == 1'b0)));

    assert_rcv_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_ni && !suspend_i && (dp_rx_i != dm_rx_i)) |=> (rcv_o == $past(rcv_diff_i)));

    assert_rcv_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!oe_ni || suspend_i) |=> !rcv_o);
endmodule

bind usb_fs_xcvr_if usb_fs_xcvr_if_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enc_dat_se0_i (enc_dat_se0_i),
    .bidir_i       (bidir_i),
    .oe_ni         (oe_ni),
    .suspend_i     (suspend_i),
    .line_rst_ni   (line_rst_ni),
    .por_i         (por_i),
    .dat_vp_i      (dat_vp_i),
    .se0_vm_i      (se0_vm_i),
    .dp_rx_i       (dp_rx_i),
    .dm_rx_i       (dm_rx_i),
    .rcv_diff_i    (rcv_diff_i),
    .dp_drv_o      (dp_drv_o),
    .dm_drv_o      (dm_drv_o),
    .line_oe_o     (line_oe_o),
    .rcv_o         (rcv_o),
    .dat_vp_o      (dat_vp_o),
    .se0_vm_o      (se0_vm_o),
    .pin_oe_o      (pin_oe_o)
);

// File: tb/usb_fs_xcvr_if_tb.sv
`timescale 1ns/1ps
module usb_fs_xcvr_if_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc, bidir, oe_n, susp, lrst_n, por, dat_i, se0_i, dp_rx, dm_rx, rdiff;
    logic dp_o, dm_o, loe_o, rcv_o, dat_o, se0_o, poe_o;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    usb_fs_xcvr_if u_dut (
        .clk_i (clk), .rst_ni (rst_n), .enc_dat_se0_i (enc), .bidir_i (bidir),
        .oe_ni (oe_n), .suspend_i (susp), .line_rst_ni (lrst_n), .por_i (por),
        .dat_vp_i (dat_i), .se0_vm_i (se0_i), .dp_rx_i (dp_rx), .dm_rx_i (dm_rx),
        .rcv_diff_i (rdiff), .dp_drv_o (dp_o), .dm_drv_o (dm_o), .line_oe_o (loe_o),
        .rcv_o (rcv_o), .dat_vp_o (dat_o), .se0_vm_o (se0_o), .pin_oe_o (poe_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic hold = 1'b0;
        {enc, bidir, oe_n, susp, lrst_n, por, dat_i, se0_i, rdiff, dp_rx, dm_rx} = '0;
        repeat (3) @(negedge clk);
        // R12: all outputs 0 in reset
        chk("R12", {1'b0, dp_o, dm_o, loe_o, rcv_o, dat_o, se0_o, poe_o}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < 2048; i++) begin
            logic rx_on, diff, rnow, e_loe, e_dp, e_dm, e_poe, e_dat, e_se0;
            string tl, tp, tr;
            {enc, bidir, oe_n, susp, lrst_n, por, dat_i, se0_i, rdiff, dp_rx, dm_rx} = i[10:0];
            rx_on = oe_n && !susp;
            diff  = dp_rx != dm_rx;
            rnow  = rx_on ? (diff ? rdiff : hold) : 1'b0;
            e_loe = !oe_n && lrst_n && !por;
            e_dp  = e_loe ? (enc ? (se0_i ? 1'b0 : dat_i) : dat_i) : 1'b0;
            e_dm  = e_loe ? (enc ? (se0_i ? 1'b0 : !dat_i) : se0_i) : 1'b0;
            e_poe = bidir && oe_n;
            e_dat = e_poe ? (enc ? (susp ? dp_rx : (diff ? rdiff : hold)) : dp_rx) : 1'b0;
            e_se0 = e_poe ? (enc ? (!dp_rx && !dm_rx) : dm_rx) : 1'b0;
            if (!e_loe) tl = "R4";
            else if (enc && se0_i) tl = "R2";
            else if (enc) tl = "R1";
            else tl = "R3";
            if (!bidir) tp = "R5";
            else if (!oe_n) tp = "R6";
            else if (enc) tp = "R8";
            else tp = "R7";
            if (!rx_on) tr = "R11";
            else if (diff) tr = "R9";
            else tr = "R10";
            if (rx_on && diff) hold = rdiff;
            @(negedge clk);
            // one cycle after the inputs were applied (R12 latency)
            chk(tl, {5'b0, loe_o, dp_o, dm_o}, {5'b0, e_loe, e_dp, e_dm});
            chk(tp, {5'b0, poe_o, dat_o, se0_o}, {5'b0, e_poe, e_dat, e_se0});
            chk(tr, {7'b0, rcv_o}, {7'b0, rnow});
        end

        // R10: held value returns to 0 after reset
        {oe_n, susp, dp_rx, dm_rx, rdiff} = 5'b10011;
        @(negedge clk);
        @(negedge clk);
        chk("R9", {7'b0, rcv_o}, 8'h01);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12", {1'b0, dp_o, dm_o, loe_o, rcv_o, dat_o, se0_o, poe_o}, 8'h00);
        rst_n = 1'b1;
        {dp_rx, dm_rx} = 2'b11;
        @(negedge clk);
        chk("R10", {7'b0, rcv_o}, 8'h00);
        finish_run();
    end
endmodule